// File: doc/BRIEF.md
# Set-Dueling Insertion Age Selector

This block decides, on every cache access, which of two insertion policies governs the addressed set. It also gives the age that a line filled into that set should get. Policy A always inserts at age 1. Policy B inserts at the oldest age, 3, in fifteen of sixteen fills and at age 1 otherwise. A 16-bit pseudo-random shift register makes that choice.

Two fixed windows of set indices act as leaders. One window always runs policy A and the other always runs policy B. Each miss in a leader set moves a shared saturating counter toward the other policy. Every other set is a follower and runs whichever policy the top bit of the counter names.

Both outputs are combinational. They follow the current set index and the current internal state, so the cache controller reads them in the same cycle as the access. Ages, victim choice, tags and data are handled elsewhere.

Top module: `set_duel_selector`

## Requirements
- R1: Sets 512 to 575 inclusive are policy-A leaders: for them use_b_o is 0 and ins_age_o is 1.
- R2: Sets 768 to 831 inclusive are policy-B leaders: for them use_b_o is 1, and ins_age_o is 1 when the low 4 bits of the random register are all zero and 3 otherwise.
- R3: Every other set index is a follower. For a follower, use_b_o equals bit 9 of the selector counter, and ins_age_o is 1 under policy A or the R2 rule under policy B.
- R4: The 10-bit selector counter counts qualified misses in leader sets. A miss in a policy-A leader adds 1, holding at 1023. A miss in a policy-B leader subtracts 1, holding at 0. A follower miss or an access without a miss leaves it unchanged.
- R5: After the asynchronous active-low reset, the counter is 512 (so followers start on policy B) and the random register is 16'hACE1.
- R6: On each clock edge with a qualified miss in any set, the random register shifts left one place and its new bit 0 is bits 15, 13, 12 and 10 XORed together. On all other edges it holds.
- R7: A miss qualifies only when access_i is also high. miss_i without access_i changes neither the counter nor the random register.
- R8: ins_age_o is always 1 or 3. Both outputs depend combinationally on set_idx_i and the current state, within the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| set_idx_i | input | 11 | Set index of the current access |
| access_i | input | 1 | Cache access strobe |
| miss_i | input | 1 | The access missed (qualified by access_i) |
| use_b_o | output | 1 | 1 when policy B governs this set |
| ins_age_o | output | 2 | Insertion age for a fill in this set (1 or 3) |

## Verification
A wrong random register value shows at the ports on the next access to a policy-B leader or a B-following set. That access reports the wrong insertion age in the same cycle. A wrong counter value stays hidden until it moves bit 9 to the other side, so the bench drives the counter through both saturation points and back across its midpoint. Any slip then shows as a follower flipping policy at the wrong miss. Misses without an access, hits and follower misses are each run in long bursts. Each burst is followed by probes of follower sets and of policy-B leaders, so a counter or register that moved on ignored stimulus shows up.

// File: rtl/set_duel_pkg.sv
package set_duel_pkg;
  typedef enum logic [1:0] {
    ROLE_FOLLOW = 2'd0,
    ROLE_LEAD_A = 2'd1,
    ROLE_LEAD_B = 2'd2
  } set_role_e;

  localparam logic [1:0] AGE_NEAR = 2'd1;
  localparam logic [1:0] AGE_FAR  = 2'd3;
endpackage

// File: rtl/set_duel_classify.sv
module set_duel_classify
  import set_duel_pkg::*;
#(
  parameter int SET_W     = 11,
  parameter int A_BASE    = 512,
  parameter int B_BASE    = 768,
  parameter int LEAD_CNT  = 64
) (
  input  logic [SET_W-1:0] set_idx_i,
  output set_role_e        role_o
);
  localparam int LEAD_LOG = $clog2(LEAD_CNT);
  localparam bit POW2     = (LEAD_CNT == (1 << LEAD_LOG)) && ((A_BASE % LEAD_CNT) == 0)
                            && ((B_BASE % LEAD_CNT) == 0);

  logic in_a, in_b;

  generate
    if (POW2) begin : g_aligned
      // aligned power-of-two windows: compare upper index bits only
      localparam int TW = SET_W - LEAD_LOG;
      localparam logic [TW-1:0] A_TAG = TW'(A_BASE >> LEAD_LOG);
      localparam logic [TW-1:0] B_TAG = TW'(B_BASE >> LEAD_LOG);
      assign in_a = (set_idx_i[SET_W-1:LEAD_LOG] == A_TAG);
      assign in_b = (set_idx_i[SET_W-1:LEAD_LOG] == B_TAG);
    end else begin : g_range
      int idx;
      assign idx  = int'({1'b0, set_idx_i});
      assign in_a = (idx >= A_BASE) && (idx < A_BASE + LEAD_CNT);
      assign in_b = (idx >= B_BASE) && (idx < B_BASE + LEAD_CNT);
    end
  endgenerate

  always_comb begin
    if (in_a)      role_o = ROLE_LEAD_A;
    else if (in_b) role_o = ROLE_LEAD_B;
    else           role_o = ROLE_FOLLOW;
  end
endmodule

// File: rtl/set_duel_psel.sv
module set_duel_psel #(
  parameter int W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  input  logic         dec_i,
  output logic [W-1:0] cnt_o,
  output logic         msb_o
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] BOT = '0;

  logic [W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (inc_i && !dec_i && cnt_q != TOP)      cnt_d = cnt_q + 1'b1;
    else if (dec_i && !inc_i && cnt_q != BOT) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= MID;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
  assign msb_o = cnt_q[W-1];
endmodule

// File: rtl/set_duel_lfsr.sv
module set_duel_lfsr #(
  parameter int           W    = 16,
  parameter logic [W-1:0] TAPS = 16'hB400,
  parameter logic [W-1:0] SEED = 16'hACE1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         step_i,
  output logic [W-1:0] state_o
);
  logic [W-1:0] state_q;
  logic         fb;

  assign fb = ^(state_q & TAPS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     state_q <= SEED;
    else if (step_i) state_q <= {state_q[W-2:0], fb};
  end

  assign state_o = state_q;
endmodule

// File: rtl/set_duel_selector.sv
module set_duel_selector
  import set_duel_pkg::*;
#(
  parameter int           SET_W    = 11,
  parameter int           A_BASE   = 512,
  parameter int           B_BASE   = 768,
  parameter int           LEAD_CNT = 64,
  parameter int           PSEL_W   = 10,
  parameter int           RND_W    = 16,
  parameter logic [15:0]  RND_TAPS = 16'hB400,
  parameter logic [15:0]  RND_SEED = 16'hACE1,
  parameter int           PICK_W   = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SET_W-1:0] set_idx_i,
  input  logic             access_i,
  input  logic             miss_i,
  output logic             use_b_o,
  output logic [1:0]       ins_age_o
);
  set_role_e          role;
  logic               miss_v;
  logic [PSEL_W-1:0]  psel_q;
  logic               psel_msb;
  logic [RND_W-1:0]   rnd_q;
  logic [1:0]         b_age;

  set_duel_classify #(
    .SET_W(SET_W), .A_BASE(A_BASE), .B_BASE(B_BASE), .LEAD_CNT(LEAD_CNT)
  ) u_classify (
    .set_idx_i(set_idx_i),
    .role_o   (role)
  );

  assign miss_v = access_i & miss_i;

  set_duel_psel #(.W(PSEL_W)) u_psel (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .inc_i (miss_v && role == ROLE_LEAD_A),
    .dec_i (miss_v && role == ROLE_LEAD_B),
    .cnt_o (psel_q),
    .msb_o (psel_msb)
  );

  set_duel_lfsr #(
    .W(RND_W), .TAPS(RND_TAPS[RND_W-1:0]), .SEED(RND_SEED[RND_W-1:0])
  ) u_lfsr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (miss_v),
    .state_o(rnd_q)
  );

  // all-zero pick field -> near insertion (1 in 2^PICK_W)
  assign b_age = (rnd_q[PICK_W-1:0] == '0) ? AGE_NEAR : AGE_FAR;

  always_comb begin
    unique case (role)
      ROLE_LEAD_A: use_b_o = 1'b0;
      ROLE_LEAD_B: use_b_o = 1'b1;
      default:     use_b_o = psel_msb;
    endcase
    ins_age_o = use_b_o ? b_age : AGE_NEAR;
  end
endmodule

// File: rtl/set_duel_sva.sv
module set_duel_sva #(
  parameter int SET_W    = 11,
  parameter int A_BASE   = 512,
  parameter int B_BASE   = 768,
  parameter int LEAD_CNT = 64,
  parameter int PSEL_W   = 10,
  parameter int RND_W    = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SET_W-1:0]  set_idx_i,
  input logic              access_i,
  input logic              miss_i,
  input logic              use_b_o,
  input logic [1:0]        ins_age_o,
  input logic [PSEL_W-1:0] psel_q,
  input logic [RND_W-1:0]  rnd_q
);
  localparam logic [PSEL_W-1:0] TOP = {PSEL_W{1'b1}};
  int  idx;
  logic lead_a, lead_b, qmiss;
  assign idx    = int'({1'b0, set_idx_i});
  assign lead_a = (idx >= A_BASE) && (idx < A_BASE + LEAD_CNT);
  assign lead_b = (idx >= B_BASE) && (idx < B_BASE + LEAD_CNT);
  assign qmiss  = access_i && miss_i;

  a_r1_lead_a_near: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_a |-> (!use_b_o && ins_age_o == 2'd1));

  a_r2_lead_b_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lead_b |-> use_b_o);

  a_r4_hold_top: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qmiss && lead_a && psel_q == TOP) |=> psel_q == TOP);

  a_r4_step_up: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qmiss && lead_a && psel_q != TOP) |=> psel_q == $past(psel_q) + 1'b1);

  a_r4_hold_bottom: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (qmiss && lead_b && psel_q == '0) |=> psel_q == '0);

  a_r7_psel_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qmiss |=> $stable(psel_q));

  a_r6_rnd_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !qmiss |=> $stable(rnd_q));

  a_r6_rnd_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rnd_q != '0);

  a_r8_age_legal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ins_age_o == 2'd1) || (ins_age_o == 2'd3));
endmodule

bind set_duel_selector set_duel_sva #(
  .SET_W(SET_W), .A_BASE(A_BASE), .B_BASE(B_BASE), .LEAD_CNT(LEAD_CNT),
  .PSEL_W(PSEL_W), .RND_W(RND_W)
) u_sva (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .set_idx_i(set_idx_i),
  .access_i (access_i),
  .miss_i   (miss_i),
  .use_b_o  (use_b_o),
  .ins_age_o(ins_age_o),
  .psel_q   (psel_q),
  .rnd_q    (rnd_q)
);

// File: tb/set_duel_selector_tb.sv
`timescale 1ns/1ps
module set_duel_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [10:0] set_idx = '0;
  logic        access = 1'b0;
  logic        miss = 1'b0;
  logic        use_b;
  logic [1:0]  ins_age;

  int checks = 0;
  int errors = 0;

  // reference state
  int m_psel;
  int m_rnd;

  always #2 clk = ~clk;

  set_duel_selector dut_i (
    .clk_i(clk), .rst_ni(rst_n), .set_idx_i(set_idx),
    .access_i(access), .miss_i(miss), .use_b_o(use_b), .ins_age_o(ins_age)
  );

  function automatic int role_of(int idx);
    if (idx >= 512 && idx <= 575) return 1;
    if (idx >= 768 && idx <= 831) return 2;
    return 0;
  endfunction

  function automatic string tag_of(int idx);
    case (role_of(idx))
      1: return "R1";
      2: return "R2,R6";
      default: return "R3,R4";
    endcase
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s idx=%0d actual=%0d expected=%0d", tag, set_idx, act, exp);
    end
  endtask

  // drive one cycle, compare before the edge, then advance the model
  task automatic step(int idx, bit acc, bit mis, string extra);
    int  role, exp_b, exp_age;
    bit  q;
    @(negedge clk);
    set_idx = 11'(idx);
    access  = acc;
    miss    = mis;
    #1;
    role    = role_of(idx);
    exp_b   = (role == 1) ? 0 : (role == 2) ? 1 : ((m_psel >> 9) & 1);
    exp_age = (exp_b == 1 && (m_rnd & 15) != 0) ? 3 : 1;
    check({tag_of(idx), " ", extra, " use_b"}, int'(use_b), exp_b);
    check({tag_of(idx), " ", extra, " age"}, int'(ins_age), exp_age);
    @(posedge clk);
    q = acc && mis;
    if (q) begin
      if (role == 1 && m_psel < 1023) m_psel++;
      if (role == 2 && m_psel > 0) m_psel--;
      m_rnd = ((m_rnd << 1) | (((m_rnd >> 15) ^ (m_rnd >> 13) ^ (m_rnd >> 12) ^ (m_rnd >> 10)) & 1)) & 16'hFFFF;
    end
  endtask

  task automatic probe(string extra);
    step(0, 1'b0, 1'b0, extra);
    step(2047, 1'b0, 1'b0, extra);
    step(800, 1'b0, 1'b0, extra);
  endtask

  initial begin
    #(4ns * 200000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    m_psel = 512;
    m_rnd  = 16'hACE1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R5: reset state, followers on B, seed nibble 1 -> far age
    #1;
    check("R5 reset use_b", int'(use_b), 1);
    check("R5 reset age", int'(ins_age), 3);
    rst_n = 1'b1;

    // R1 boundaries, R3 neighbours
    step(512, 1'b0, 1'b0, "edge");
    step(575, 1'b0, 1'b0, "edge");
    step(511, 1'b0, 1'b0, "edge");
    step(576, 1'b0, 1'b0, "edge");
    step(767, 1'b0, 1'b0, "edge");
    step(768, 1'b0, 1'b0, "edge");
    step(831, 1'b0, 1'b0, "edge");
    step(832, 1'b0, 1'b0, "edge");

    // R4: drive counter to top saturation
    for (int i = 0; i < 700; i++) step(512 + (i % 64), 1'b1, 1'b1, "sat_top");
    probe("after_top");
    // R4: down past midpoint to bottom saturation
    for (int i = 0; i < 1200; i++) begin
      step(768 + (i % 64), 1'b1, 1'b1, "sat_bot");
      if (i % 97 == 0) probe("descend");
    end
    probe("after_bot");
    // R7: miss without access ignored
    for (int i = 0; i < 600; i++) step(512 + (i % 64), 1'b0, 1'b1, "R7 no_access");
    probe("R7 post");
    // R4: hits do not move counter
    for (int i = 0; i < 600; i++) step(512 + (i % 64), 1'b1, 1'b0, "R4 hit");
    probe("R4 post_hit");
    // R4/R6: follower misses move only the random register
    for (int i = 0; i < 600; i++) step((i * 37) % 512, 1'b1, 1'b1, "R6 follower_miss");
    probe("R4 post_follow");
    // climb back across midpoint
    for (int i = 0; i < 530; i++) begin
      step(512 + (i % 64), 1'b1, 1'b1, "climb");
      if (i % 53 == 0) probe("climb");
    end
    // R8: mixed traffic
    for (int i = 0; i < 20000; i++) begin
      int r, idx;
      r = int'($urandom_range(0, 3));
      idx = (r == 0) ? int'($urandom_range(512, 575)) :
            (r == 1) ? int'($urandom_range(768, 831)) : int'($urandom_range(0, 2047));
      step(idx, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), "R8 mixed");
      checks++;
      if (!(ins_age == 2'd1 || ins_age == 2'd3)) begin
        errors++;
        $display("FAIL R8 age actual=%0d expected=1or3", ins_age);
      end
    end
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule